// File: doc/BRIEF.md
# Input Clock Gate and Audio Link Power Controller

This block decides, every cycle, whether the external input clock may be ignored inside the chip. The decision depends on the host bus mode, the powerdown status of each DSP core, the power state of the serial audio link, the USB suspend status, a host-bus restart request and a software force-on bit. Any wake condition turns the clock enable back on in the same cycle. The enable is allowed to fall only after the idle conditions have held for a programmable number of consecutive cycles, which filters out short glitches.

The block also holds the power state of the serial audio link and drives its three control outputs: the link reset, the bit clock enable and the frame sync enable. A 2-bit command selects active, warm powerdown or cold powerdown. When the link leaves cold powerdown for active, it passes through one intermediate cycle in which the reset is already released and both clocks are still halted.

Top module: `clkgate_link_ctrl`

## Requirements
- R1: In PCI mode (`bus_mode`=0) or CardBus mode (`bus_mode`=1), `clk_en` may be low only when every bit of `dsp_pd` is 1, the link is powered down, the force-on bit is 0 and `host_restart` is 0.
- R2: In USB mode (`bus_mode`=2), the conditions of R1 must hold and `usb_suspended` must also be 1 before `clk_en` may go low.
- R3: In Sub-ISA mode (`bus_mode`=3), `clk_en` is always 1.
- R4: In cold link powerdown (`link_cmd`=2), `link_reset` is 1 and both `bitclk_en` and `sync_en` are 0.
- R5: In warm link powerdown (`link_cmd`=1), `link_reset`, `bitclk_en` and `sync_en` are all 0. In the active link state (`link_cmd`=0), `link_reset` is 0 and both enables are 1. A new link command takes effect on the next clock edge.
- R6: `clk_en` returns to 1 in the same cycle as any wake event, with no register in the path. Wake events are: a DSP leaving powerdown, `link_cmd` set to active, `usb_suspended` falling in USB mode, and `host_restart` set.
- R7: `clk_en` falls only in the cycle after the idle condition has held at HOLD_CYCLES (default 4) consecutive rising edges. Any cycle in which the condition is not met restarts the count.
- R8: On a cold-to-active command, `link_reset` goes to 0 on the first edge while both clock enables stay 0. The enables go to 1 on the second edge.
- R9: The force-on bit is loaded from `cfg_wr_data` on an edge where `cfg_wr_en` is 1 and resets to 0. From the following cycle, a set bit keeps `clk_en` at 1.
- R10: After reset, the link is in cold powerdown and `clk_en` is 1.
- R11: `link_cmd`=3 has no effect: the link keeps its current state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_mode | input | 2 | Host bus mode: 0 PCI, 1 CardBus, 2 USB, 3 Sub-ISA |
| dsp_pd | input | NUM_DSP | Per-core powerdown status, 1 = powered down |
| link_cmd | input | 2 | Link power command: 0 active, 1 warm, 2 cold, 3 hold |
| usb_suspended | input | 1 | USB interface is suspended |
| host_restart | input | 1 | Host bus restart request (wake) |
| cfg_wr_en | input | 1 | Write strobe for the force-on bit |
| cfg_wr_data | input | 1 | Value written to the force-on bit |
| clk_en | output | 1 | 1 = input clock used internally |
| link_reset | output | 1 | Audio link reset, active high |
| bitclk_en | output | 1 | Audio link bit clock enable |
| sync_en | output | 1 | Audio link frame sync enable |

## Verification
The assertions assume that every input is a settled level at each rising edge. They also assume that `link_cmd`, `dsp_pd` and the bus mode are supplied directly, not derived from `clk_en`, so that no combinational loop exists through the wake path. The bench meets these assumptions by changing inputs only just after a falling edge and driving them from a fixed table or from directed steps. It never feeds an output back into an input. Bus mode changes happen only between table rows, and the filter assertion is written to allow such a change.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

  typedef enum logic [1:0] {
    BUS_PCI     = 2'd0,
    BUS_CARDBUS = 2'd1,
    BUS_USB     = 2'd2,
    BUS_SUBISA  = 2'd3
  } bus_mode_e;

  typedef enum logic [1:0] {
    LCMD_ACTIVE = 2'd0,
    LCMD_WARM   = 2'd1,
    LCMD_COLD   = 2'd2,
    LCMD_HOLD   = 2'd3
  } link_cmd_e;

  typedef enum logic [1:0] {
    LS_ACTIVE  = 2'd0,
    LS_WARM    = 2'd1,
    LS_COLD    = 2'd2,
    LS_RELEASE = 2'd3
  } link_state_e;

  typedef struct packed {
    logic rst;
    logic bclk;
    logic sync;
  } link_pins_t;

  // Does the bus mode allow the clock to be ignored at all?
  function automatic logic mode_permits_gate(logic [1:0] mode, logic usb_susp);
    case (mode)
      BUS_PCI, BUS_CARDBUS: return 1'b1;
      BUS_USB:              return usb_susp;
      default:              return 1'b0;
    endcase
  endfunction

  // Pin levels for each link state.
  function automatic link_pins_t pins_for_state(link_state_e s);
    link_pins_t p;
    case (s)
      LS_ACTIVE: p = '{rst: 1'b0, bclk: 1'b1, sync: 1'b1};
      LS_COLD:   p = '{rst: 1'b1, bclk: 1'b0, sync: 1'b0};
      default:   p = '{rst: 1'b0, bclk: 1'b0, sync: 1'b0};
    endcase
    return p;
  endfunction

  // Link state transition for one command.
  function automatic link_state_e next_link_state(link_state_e cur, logic [1:0] cmd);
    link_state_e n;
    n = cur;
    case (cmd)
      LCMD_ACTIVE: n = (cur == LS_COLD) ? LS_RELEASE : LS_ACTIVE;
      LCMD_WARM:   n = LS_WARM;
      LCMD_COLD:   n = LS_COLD;
      default:     n = cur;
    endcase
    return n;
  endfunction

  // Saturating increment of the idle run counter.
  function automatic int unsigned run_step(int unsigned cnt, logic idle, int unsigned limit);
    if (!idle) return 0;
    if (cnt >= limit) return limit;
    return cnt + 1;
  endfunction

endpackage

// File: rtl/clkgate_force_reg.sv
module clkgate_force_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_data,
  output logic force_on
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     force_on <= 1'b0;
    else if (wr_en) force_on <= wr_data;
  end
endmodule

// File: rtl/clkgate_link_fsm.sv
module clkgate_link_fsm
  import clkgate_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cmd,
  output link_state_e state,
  output logic        link_down,
  output logic        pin_rst,
  output logic        pin_bclk,
  output logic        pin_sync
);
  link_state_e state_q, state_d;
  link_pins_t  pins;

  always_comb state_d = next_link_state(state_q, cmd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LS_COLD;
    else        state_q <= state_d;
  end

  always_comb begin
    pins      = pins_for_state(state_q);
    // Link counts as down only if it is down now and is not being woken.
    link_down = (state_q != LS_ACTIVE) && (cmd != LCMD_ACTIVE);
  end

  assign state    = state_q;
  assign pin_rst  = pins.rst;
  assign pin_bclk = pins.bclk;
  assign pin_sync = pins.sync;
endmodule

// File: rtl/clkgate_idle_filter.sv
module clkgate_idle_filter #(
  parameter int unsigned HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic idle_ok,
  output logic clk_en,
  output logic hold_met
);
  localparam int unsigned CW = $clog2(HOLD + 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= CW'(clkgate_pkg::run_step(int'(run_q), idle_ok, HOLD));
  end

  assign hold_met = (run_q == CW'(HOLD));
  // Wake path is purely combinational from idle_ok.
  assign clk_en   = !(idle_ok && hold_met);
endmodule

// File: rtl/clkgate_link_ctrl.sv
module clkgate_link_ctrl
  import clkgate_pkg::*;
#(
  parameter int unsigned NUM_DSP     = 2,
  parameter int unsigned HOLD_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         bus_mode,
  input  logic [NUM_DSP-1:0] dsp_pd,
  input  logic [1:0]         link_cmd,
  input  logic               usb_suspended,
  input  logic               host_restart,
  input  logic               cfg_wr_en,
  input  logic               cfg_wr_data,
  output logic               clk_en,
  output logic               link_reset,
  output logic               bitclk_en,
  output logic               sync_en
);
  logic        force_on_q;
  logic        link_down;
  logic        dsp_all_down;
  logic        mode_ok;
  logic        idle_ok;
  logic        hold_met;
  link_state_e link_state;

  clkgate_force_reg u_force (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .force_on(force_on_q)
  );

  clkgate_link_fsm u_link (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (link_cmd),
    .state    (link_state),
    .link_down(link_down),
    .pin_rst  (link_reset),
    .pin_bclk (bitclk_en),
    .pin_sync (sync_en)
  );

  always_comb begin
    dsp_all_down = &dsp_pd;
    mode_ok      = mode_permits_gate(bus_mode, usb_suspended);
    idle_ok      = dsp_all_down && link_down && !force_on_q && !host_restart && mode_ok;
  end

  clkgate_idle_filter #(.HOLD(HOLD_CYCLES)) u_filt (
    .clk     (clk),
    .rst_n   (rst_n),
    .idle_ok (idle_ok),
    .clk_en  (clk_en),
    .hold_met(hold_met)
  );
endmodule

// File: rtl/clkgate_link_ctrl_chk.sv
module clkgate_link_ctrl_chk #(
  parameter int unsigned NUM_DSP = 2,
  parameter int unsigned HOLD    = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         bus_mode,
  input logic [NUM_DSP-1:0] dsp_pd,
  input logic [1:0]         link_cmd,
  input logic               usb_suspended,
  input logic               host_restart,
  input logic               cfg_wr_en,
  input logic               cfg_wr_data,
  input logic               clk_en,
  input logic               link_reset,
  input logic               bitclk_en,
  input logic               sync_en,
  input logic               force_on_q,
  input logic               idle_ok
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  logic [CW-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    seen_q <= '0;
    else if (!idle_ok)             seen_q <= '0;
    else if (seen_q != CW'(HOLD))  seen_q <= seen_q + 1'b1;
  end

  AST_PCI_DSP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !(&dsp_pd) |-> clk_en); // R1
  AST_USB_AWAKE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_mode == 2'd2 && !usb_suspended) |-> clk_en); // R2
  AST_SUBISA_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_mode == 2'd3) |-> clk_en); // R3
  AST_COLD_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    link_reset |-> (!bitclk_en && !sync_en)); // R4
  AST_CLK_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    bitclk_en == sync_en); // R5
  AST_HOST_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_restart || link_cmd == 2'd0) |-> clk_en); // R6
  AST_FILTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> (idle_ok && seen_q == CW'(HOLD))); // R7
  AST_RELEASE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_reset) |-> !bitclk_en); // R8
  AST_FORCE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> (force_on_q == $past(cfg_wr_data))); // R9
  AST_FORCE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    force_on_q |-> clk_en); // R9
  AST_HOLD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (link_cmd == 2'd3) |=> $stable(link_reset) && $stable(bitclk_en)); // R11
endmodule

bind clkgate_link_ctrl clkgate_link_ctrl_chk #(
  .NUM_DSP(NUM_DSP),
  .HOLD   (HOLD_CYCLES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_mode     (bus_mode),
  .dsp_pd       (dsp_pd),
  .link_cmd     (link_cmd),
  .usb_suspended(usb_suspended),
  .host_restart (host_restart),
  .cfg_wr_en    (cfg_wr_en),
  .cfg_wr_data  (cfg_wr_data),
  .clk_en       (clk_en),
  .link_reset   (link_reset),
  .bitclk_en    (bitclk_en),
  .sync_en      (sync_en),
  .force_on_q   (force_on_q),
  .idle_ok      (idle_ok)
);

// File: tb/sim_clkgate_link_ctrl.sv
module sim_clkgate_link_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_mode = 2'd0;
  logic [1:0] dsp_pd = 2'b11;
  logic [1:0] link_cmd = 2'd2;
  logic       usb_suspended = 1'b0;
  logic       host_restart = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic       cfg_wr_data = 1'b0;
  logic       clk_en, link_reset, bitclk_en, sync_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  clkgate_link_ctrl #(.NUM_DSP(2), .HOLD_CYCLES(4)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .dsp_pd(dsp_pd),
    .link_cmd(link_cmd), .usb_suspended(usb_suspended),
    .host_restart(host_restart), .cfg_wr_en(cfg_wr_en),
    .cfg_wr_data(cfg_wr_data), .clk_en(clk_en), .link_reset(link_reset),
    .bitclk_en(bitclk_en), .sync_en(sync_en)
  );

  // {mode, dsp_pd, cmd, usb_susp, host_restart, exp clk_en, exp rst, exp bclk, exp sync}
  localparam int NV = 10;
  localparam logic [12:0] VEC [NV] = '{
    {2'd0, 2'b11, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd0, 2'b01, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {2'd1, 2'b11, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'd1, 2'b11, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    {2'd2, 2'b11, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {2'd2, 2'b11, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd3, 2'b11, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {2'd0, 2'b11, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'd0, 2'b10, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'd2, 2'b11, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pins(input string req, input logic r, input logic b, input logic s);
    chk(req, link_reset, r, "link_reset");
    chk(req, bitclk_en, b, "bitclk_en");
    chk(req, sync_en, s, "sync_en");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    chk("R10", clk_en, 1'b1, "clk_en after reset");
    pins("R10", 1'b1, 1'b0, 1'b0);
    // R7 filter: PCI, all idle, cold link since reset
    step(3);
    chk("R7", clk_en, 1'b1, "after 3 idle edges");
    step(1);
    chk("R7", clk_en, 1'b0, "after 4 idle edges");
    // R7 a break restarts the count
    host_restart = 1'b1; step(1); host_restart = 1'b0;
    step(3);
    chk("R7", clk_en, 1'b1, "restart count 3 edges");
    step(1);
    chk("R7", clk_en, 1'b0, "restart count 4 edges");

    // R6 same-cycle wake events
    dsp_pd = 2'b01; #1;
    chk("R6", clk_en, 1'b1, "dsp wake");
    dsp_pd = 2'b11; step(5);
    chk("R1", clk_en, 1'b0, "re-gated");
    host_restart = 1'b1; #1;
    chk("R6", clk_en, 1'b1, "host restart wake");
    host_restart = 1'b0; step(5);
    link_cmd = 2'd0; #1;
    chk("R6", clk_en, 1'b1, "link active wake");
    link_cmd = 2'd2; step(6);
    bus_mode = 2'd2; usb_suspended = 1'b1; step(5);
    chk("R2", clk_en, 1'b0, "usb suspended gated");
    usb_suspended = 1'b0; #1;
    chk("R6", clk_en, 1'b1, "usb resume wake");

    // Table walk: steady state per row (R1..R5)
    for (int i = 0; i < NV; i++) begin
      {bus_mode, dsp_pd, link_cmd, usb_suspended, host_restart} = VEC[i][12:4];
      step(6);
      chk("R1 R2 R3", clk_en, VEC[i][3], $sformatf("row %0d clk_en", i));
      pins("R4 R5", VEC[i][2], VEC[i][1], VEC[i][0]);
    end
    host_restart = 1'b0;

    // R8 cold to active passes through release
    link_cmd = 2'd2; step(2);
    pins("R4", 1'b1, 1'b0, 1'b0);
    link_cmd = 2'd0; step(1);
    pins("R8", 1'b0, 1'b0, 1'b0);
    step(1);
    pins("R8", 1'b0, 1'b1, 1'b1);

    // R11 hold command leaves state alone
    link_cmd = 2'd3; step(3);
    pins("R11", 1'b0, 1'b1, 1'b1);
    link_cmd = 2'd1; step(1);
    pins("R5", 1'b0, 1'b0, 1'b0);
    link_cmd = 2'd3; step(3);
    pins("R11", 1'b0, 1'b0, 1'b0);

    // R9 force-on bit
    bus_mode = 2'd0; dsp_pd = 2'b11; link_cmd = 2'd2; usb_suspended = 1'b0;
    step(6);
    chk("R9", clk_en, 1'b0, "gated before force");
    cfg_wr_en = 1'b1; cfg_wr_data = 1'b1; #1;
    chk("R9", clk_en, 1'b0, "force not yet effective");
    step(1);
    cfg_wr_en = 1'b0; cfg_wr_data = 1'b0; #1;
    chk("R9", clk_en, 1'b1, "force effective");
    step(8);
    chk("R9", clk_en, 1'b1, "force holds");
    cfg_wr_en = 1'b1; step(1); cfg_wr_en = 1'b0;
    step(3);
    chk("R7", clk_en, 1'b1, "after clear 3 edges");
    step(1);
    chk("R9", clk_en, 1'b0, "after clear 4 edges");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule